// File: doc/BRIEF.md
# Eight-bit Configurable Datapath with Masked Comparators

This block is the arithmetic core of small embedded functions: counters, timers, pulse-width generators, shifters. It holds two accumulators and two data registers. Each clock cycle, a control word may run one single-cycle ALU operation on two operands picked from those four registers. The result then passes through a post-ALU stage that can shift or swap nibbles and can OR in a mask. The final value is written back to one accumulator, or to neither. The two data registers load only from their own input ports.

Two comparators run in parallel. Each picks its two operands from the four registers and applies its own bit mask. Each reports a registered equal flag and a registered less-than flag. Registered zero and all-ones flags on each accumulator support terminal-count detection. Reset is synchronous and active high. Every output comes from a flop.

Top module: `dp8_core`

## Requirements
- R1: While `rst` is high, every clock edge clears the four registers, `shift_out`, all comparator flags and all accumulator flags to zero.
- R2: When `op_valid` is high, the ALU applies `op_code` to operands A and B with 8-bit wrap-around: 0 pass A, 1 A+1, 2 A-1, 3 A+B, 4 A-B, 5 A AND B, 6 A OR B, 7 A XOR B.
- R3: `op_srca`, `op_srcb` and each comparator operand select use one encoding: 0 accumulator 0, 1 accumulator 1, 2 data register 0, 3 data register 1.
- R4: `op_shift` modes are 0 none, 1 left, 2 right, 3 nibble swap. Left shift moves `shift_in` into bit 0 and sends bit 7 to `shift_out`. Right shift moves `shift_in` into bit 7 and sends bit 0 to `shift_out`. For none and swap, `shift_out` becomes 0. `shift_out` changes only on edges where `op_valid` is high.
- R5: When `op_mask_en` is high, `or_mask` is ORed into the value after the shift stage. This happens for any ALU operation and any shift mode.
- R6: `op_dest` 1 writes the final value to accumulator 0, and 2 writes it to accumulator 1. With `op_dest` 0 or 3, or with `op_valid` low, both accumulators keep their values.
- R7: A data register takes its load value on the edge where its load enable is high. It keeps its value otherwise. The ALU never writes it.
- R8: On each edge, comparator i registers `eq` = ((A AND M) == (B AND M)) and `lt` = ((A AND M) < (B AND M)), unsigned. A and B are the register contents before that edge, and M is its mask. A mask bit of 1 means that bit position is compared.
- R9: One edge after reset is released, and on every later edge, each accumulator's zero flag is high exactly when that accumulator's new value is 0x00. Its ones flag is high exactly when the new value is 0xFF. The flags therefore agree with the accumulator outputs in the same cycle.
- R10: The two comparators are independent. Each uses its own selects and mask, taken from field i of the packed select and mask ports. An all-zero mask gives eq=1 and lt=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute the control word this cycle |
| op_code | input | 3 | ALU operation |
| op_srca | input | 2 | Operand A select |
| op_srcb | input | 2 | Operand B select |
| op_shift | input | 2 | Post-ALU shift mode |
| op_mask_en | input | 1 | Apply OR mask to result |
| op_dest | input | 2 | Write-back target |
| or_mask | input | 8 | Mask ORed into result |
| shift_in | input | 1 | Bit shifted into the result |
| ld0_en | input | 1 | Load data register 0 |
| ld0_val | input | 8 | Load value for data register 0 |
| ld1_en | input | 1 | Load data register 1 |
| ld1_val | input | 8 | Load value for data register 1 |
| cmp_asel | input | 4 | Comparator A selects, 2 bits each |
| cmp_bsel | input | 4 | Comparator B selects, 2 bits each |
| cmp_mask | input | 16 | Comparator masks, 8 bits each |
| acc0_q | output | 8 | Accumulator 0 |
| acc1_q | output | 8 | Accumulator 1 |
| dreg0_q | output | 8 | Data register 0 |
| dreg1_q | output | 8 | Data register 1 |
| shift_out | output | 1 | Bit shifted out of the result |
| cmp_eq | output | 2 | Masked equal flags |
| cmp_lt | output | 2 | Masked less-than flags |
| acc0_zero | output | 1 | Accumulator 0 is 0x00 |
| acc1_zero | output | 1 | Accumulator 1 is 0x00 |
| acc0_ones | output | 1 | Accumulator 0 is 0xFF |
| acc1_ones | output | 1 | Accumulator 1 is 0xFF |

## Verification
All four registers drive output ports. A wrong ALU result, a wrong operand select, a wrong shift or a misplaced write shows up as a wrong accumulator value one cycle after the control word. A corrupted register also reaches the comparator flags one cycle later, because the flags sample the register contents from before the edge. A bad terminal-count flag shows at once, as a mismatch with the accumulator value on the same cycle. A lost or stray write is caught by the next comparison of all register outputs.

// File: rtl/dp8_pkg.sv
package dp8_pkg;
  localparam int NREG  = 4;
  localparam int SEL_W = 2;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_INC  = 3'd1,
    OP_DEC  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_AND  = 3'd5,
    OP_OR   = 3'd6,
    OP_XOR  = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_LEFT  = 2'd1,
    SH_RIGHT = 2'd2,
    SH_SWAP  = 2'd3
  } shift_e;

  typedef enum logic [1:0] {
    DST_OFF0 = 2'd0,
    DST_ACC0 = 2'd1,
    DST_ACC1 = 2'd2,
    DST_OFF3 = 2'd3
  } dest_e;
endpackage

// File: rtl/dp8_alu.sv
module dp8_alu
  import dp8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (op)
      OP_PASS: y = a;
      OP_INC:  y = a + ONE;
      OP_DEC:  y = a - ONE;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/dp8_shift.sv
module dp8_shift
  import dp8_pkg::*;
#(
  parameter int W = 8
) (
  input  shift_e         mode,
  input  logic [W-1:0]   din,
  input  logic           sin,
  input  logic           mask_en,
  input  logic [W-1:0]   mask,
  output logic [W-1:0]   dout,
  output logic           sout
);
  localparam int H = W / 2;

  logic [W-1:0] shifted;

  always_comb begin
    unique case (mode)
      SH_LEFT: begin
        shifted = {din[W-2:0], sin};
        sout    = din[W-1];
      end
      SH_RIGHT: begin
        shifted = {sin, din[W-1:1]};
        sout    = din[0];
      end
      SH_SWAP: begin
        shifted = {din[H-1:0], din[W-1:H]};
        sout    = 1'b0;
      end
      default: begin
        shifted = din;
        sout    = 1'b0;
      end
    endcase
    dout = mask_en ? (shifted | mask) : shifted;
  end
endmodule

// File: rtl/dp8_cmp.sv
module dp8_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  output logic         eq,
  output logic         lt
);
  logic [W-1:0] am, bm;

  always_comb begin
    am = a & m;
    bm = b & m;
    eq = (am == bm);
    lt = (am < bm);
  end
endmodule

// File: rtl/dp8_core.sv
module dp8_core
  import dp8_pkg::*;
#(
  parameter int W    = 8,
  parameter int NCMP = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_valid,
  input  logic [2:0]            op_code,
  input  logic [SEL_W-1:0]      op_srca,
  input  logic [SEL_W-1:0]      op_srcb,
  input  logic [1:0]            op_shift,
  input  logic                  op_mask_en,
  input  logic [1:0]            op_dest,
  input  logic [W-1:0]          or_mask,
  input  logic                  shift_in,
  input  logic                  ld0_en,
  input  logic [W-1:0]          ld0_val,
  input  logic                  ld1_en,
  input  logic [W-1:0]          ld1_val,
  input  logic [SEL_W*NCMP-1:0] cmp_asel,
  input  logic [SEL_W*NCMP-1:0] cmp_bsel,
  input  logic [W*NCMP-1:0]     cmp_mask,
  output logic [W-1:0]          acc0_q,
  output logic [W-1:0]          acc1_q,
  output logic [W-1:0]          dreg0_q,
  output logic [W-1:0]          dreg1_q,
  output logic                  shift_out,
  output logic [NCMP-1:0]       cmp_eq,
  output logic [NCMP-1:0]       cmp_lt,
  output logic                  acc0_zero,
  output logic                  acc1_zero,
  output logic                  acc0_ones,
  output logic                  acc1_ones
);
  localparam logic [W-1:0] ALL1 = '1;

  // Register file view used by every operand selector
  logic [W-1:0] regs_v [NREG];

  always_comb begin
    regs_v[0] = acc0_q;
    regs_v[1] = acc1_q;
    regs_v[2] = dreg0_q;
    regs_v[3] = dreg1_q;
  end

  logic [W-1:0] opa, opb, alu_y, fin;
  logic         sout_c;

  assign opa = regs_v[op_srca];
  assign opb = regs_v[op_srcb];

  dp8_alu #(.W(W)) u_alu (
    .op (alu_op_e'(op_code)),
    .a  (opa),
    .b  (opb),
    .y  (alu_y)
  );

  dp8_shift #(.W(W)) u_shift (
    .mode    (shift_e'(op_shift)),
    .din     (alu_y),
    .sin     (shift_in),
    .mask_en (op_mask_en),
    .mask    (or_mask),
    .dout    (fin),
    .sout    (sout_c)
  );

  // Comparators: combinational compare, registered below
  logic [NCMP-1:0] eq_c, lt_c;

  for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
    dp8_cmp #(.W(W)) u_cmp (
      .a  (regs_v[cmp_asel[SEL_W*gi +: SEL_W]]),
      .b  (regs_v[cmp_bsel[SEL_W*gi +: SEL_W]]),
      .m  (cmp_mask[W*gi +: W]),
      .eq (eq_c[gi]),
      .lt (lt_c[gi])
    );
  end

  // Next accumulator values
  logic [W-1:0] acc0_nx, acc1_nx;
  logic         wr0, wr1;

  always_comb begin
    wr0 = op_valid && (dest_e'(op_dest) == DST_ACC0);
    wr1 = op_valid && (dest_e'(op_dest) == DST_ACC1);
    acc0_nx = wr0 ? fin : acc0_q;
    acc1_nx = wr1 ? fin : acc1_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc0_q    <= '0;
      acc1_q    <= '0;
      dreg0_q   <= '0;
      dreg1_q   <= '0;
      shift_out <= 1'b0;
      cmp_eq    <= '0;
      cmp_lt    <= '0;
      acc0_zero <= 1'b0;
      acc1_zero <= 1'b0;
      acc0_ones <= 1'b0;
      acc1_ones <= 1'b0;
    end else begin
      acc0_q    <= acc0_nx;
      acc1_q    <= acc1_nx;
      if (ld0_en) dreg0_q <= ld0_val;
      if (ld1_en) dreg1_q <= ld1_val;
      if (op_valid) shift_out <= sout_c;
      cmp_eq    <= eq_c;
      cmp_lt    <= lt_c;
      acc0_zero <= (acc0_nx == '0);
      acc1_zero <= (acc1_nx == '0);
      acc0_ones <= (acc0_nx == ALL1);
      acc1_ones <= (acc1_nx == ALL1);
    end
  end
endmodule

// File: rtl/dp8_core_chk.sv
module dp8_core_chk #(
  parameter int W    = 8,
  parameter int NCMP = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [2:0]      op_code,
  input logic [1:0]      op_srca,
  input logic [1:0]      op_shift,
  input logic [1:0]      op_dest,
  input logic            ld0_en,
  input logic [W-1:0]    ld0_val,
  input logic            ld1_en,
  input logic [W-1:0]    ld1_val,
  input logic [W-1:0]    acc0_q,
  input logic [W-1:0]    acc1_q,
  input logic [W-1:0]    dreg0_q,
  input logic [W-1:0]    dreg1_q,
  input logic            shift_out,
  input logic [NCMP-1:0] cmp_eq,
  input logic [NCMP-1:0] cmp_lt,
  input logic            acc0_zero,
  input logic            acc0_ones
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc0_q == '0) && (acc1_q == '0) && (dreg0_q == '0) &&
            (dreg1_q == '0) && (cmp_eq == '0) && (cmp_lt == '0) && !shift_out);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(acc0_q) && $stable(acc1_q));

  assert_no_dest_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_dest == 2'd0 || op_dest == 2'd3)) |=>
      $stable(acc0_q) && $stable(acc1_q));

  assert_load0_R7: assert property (@(posedge clk) disable iff (rst)
    ld0_en |=> dreg0_q == $past(ld0_val));

  assert_load1_R7: assert property (@(posedge clk) disable iff (rst)
    ld1_en |=> dreg1_q == $past(ld1_val));

  assert_dhold_R7: assert property (@(posedge clk) disable iff (rst)
    (!ld0_en && !ld1_en) |=> $stable(dreg0_q) && $stable(dreg1_q));

  assert_shl_out_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_shift == 2'd1 && op_code == 3'd0 && op_srca == 2'd0) |=>
      shift_out == $past(acc0_q[W-1]));

  assert_sout_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(shift_out));

  assert_flags_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (acc0_zero == (acc0_q == '0)) && (acc0_ones == (acc0_q == '1)));

  for (genvar gi = 0; gi < NCMP; gi++) begin : g_excl
    assert_cmp_excl_R8: assert property (@(posedge clk) disable iff (rst)
      !(cmp_eq[gi] && cmp_lt[gi]));
  end
endmodule

bind dp8_core dp8_core_chk #(.W(W), .NCMP(NCMP)) u_chk (.*);

// File: tb/sim_dp8_core.sv
module sim_dp8_core;
  localparam int W  = 8;
  localparam int N  = 2;
  localparam int VW = 4*W + 1 + 2*N + 4;

  typedef struct {
    string          tag;
    logic [VW-1:0]  v;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst;
  logic           op_valid;
  logic [2:0]     op_code;
  logic [1:0]     op_srca, op_srcb, op_shift, op_dest;
  logic           op_mask_en;
  logic [W-1:0]   or_mask;
  logic           shift_in;
  logic           ld0_en, ld1_en;
  logic [W-1:0]   ld0_val, ld1_val;
  logic [2*N-1:0] cmp_asel, cmp_bsel;
  logic [W*N-1:0] cmp_mask;
  logic [W-1:0]   acc0_q, acc1_q, dreg0_q, dreg1_q;
  logic           shift_out;
  logic [N-1:0]   cmp_eq, cmp_lt;
  logic           acc0_zero, acc1_zero, acc0_ones, acc1_ones;

  dp8_core #(.W(W), .NCMP(N)) u0 (.*);

  // Bench model state
  logic [W-1:0] m_r [4];
  logic         m_so;
  logic [N-1:0] m_eq, m_lt;
  logic         m_z0, m_z1, m_f0, m_f1;

  function automatic logic [W-1:0] ref_alu(input logic [2:0] op,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      3'd0: return a;
      3'd1: return W'(a + 1);
      3'd2: return W'(a - 1);
      3'd3: return W'(a + b);
      3'd4: return W'(a - b);
      3'd5: return a & b;
      3'd6: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic step(input string tag);
    item_t it;
    logic [W-1:0] pre [4];
    logic [W-1:0] res;
    for (int k = 0; k < 4; k++) pre[k] = m_r[k];
    if (rst) begin
      for (int k = 0; k < 4; k++) m_r[k] = '0;
      m_so = 0; m_eq = '0; m_lt = '0;
      m_z0 = 0; m_z1 = 0; m_f0 = 0; m_f1 = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic [W-1:0] mk, xa, xb;
        mk = cmp_mask[W*i +: W];
        xa = pre[cmp_asel[2*i +: 2]] & mk;
        xb = pre[cmp_bsel[2*i +: 2]] & mk;
        m_eq[i] = (xa == xb);
        m_lt[i] = (xa < xb);
      end
      if (op_valid) begin
        res = ref_alu(op_code, pre[op_srca], pre[op_srcb]);
        case (op_shift)
          2'd1: begin m_so = res[W-1]; res = {res[W-2:0], shift_in}; end
          2'd2: begin m_so = res[0];   res = {shift_in, res[W-1:1]}; end
          2'd3: begin m_so = 1'b0;     res = {res[3:0], res[7:4]};   end
          default: m_so = 1'b0;
        endcase
        if (op_mask_en) res = res | or_mask;
        if (op_dest == 2'd1) m_r[0] = res;
        if (op_dest == 2'd2) m_r[1] = res;
      end
      if (ld0_en) m_r[2] = ld0_val;
      if (ld1_en) m_r[3] = ld1_val;
      m_z0 = (m_r[0] == 0);    m_z1 = (m_r[1] == 0);
      m_f0 = (m_r[0] == 8'hFF); m_f1 = (m_r[1] == 8'hFF);
    end
    it.tag = tag;
    it.v = {m_r[0], m_r[1], m_r[2], m_r[3], m_so, m_eq, m_lt, m_z0, m_z1, m_f0, m_f1};
    @(posedge clk);
    #1;
    q.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: pops expected items and compares them with the outputs
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      logic [VW-1:0] got;
      it = q.pop_front();
      got = {acc0_q, acc1_q, dreg0_q, dreg1_q, shift_out, cmp_eq, cmp_lt,
             acc0_zero, acc1_zero, acc0_ones, acc1_ones};
      checks++;
      if (got !== it.v) begin
        errors++;
        $display("FAIL %s got=%h exp=%h", it.tag, got, it.v);
      end
    end
  end

  task automatic idle();
    op_valid = 0; ld0_en = 0; ld1_en = 0; op_mask_en = 0; op_shift = 2'd0;
  endtask

  task automatic ctl(input logic [2:0] op, input logic [1:0] sa, input logic [1:0] sb,
                     input logic [1:0] sh, input logic me, input logic [1:0] dst);
    op_valid = 1; op_code = op; op_srca = sa; op_srcb = sb;
    op_shift = sh; op_mask_en = me; op_dest = dst;
  endtask

  initial begin
    rst = 1; op_code = 0; op_srca = 0; op_srcb = 0; op_dest = 0;
    or_mask = 8'h30; shift_in = 0; ld0_val = 0; ld1_val = 0;
    idle();
    cmp_asel = {2'd1, 2'd0};
    cmp_bsel = {2'd3, 2'd2};
    cmp_mask = {8'hF0, 8'h0F};
    step("R1 reset state");
    step("R1 reset held");
    rst = 0;
    step("R9 flags after reset release");
    ld0_en = 1; ld0_val = 8'h3C; ld1_en = 1; ld1_val = 8'hA5;
    step("R7 load both data registers");
    idle(); step("R7 R8 data hold and compare");
    ctl(3'd0, 2'd2, 2'd0, 2'd0, 0, 2'd1); step("R3 pass D0 to A0");
    ctl(3'd3, 2'd0, 2'd3, 2'd0, 0, 2'd2); step("R2 add A0+D1 to A1");
    ctl(3'd4, 2'd0, 2'd3, 2'd0, 0, 2'd1); step("R2 sub wrap A0-D1");
    ctl(3'd5, 2'd1, 2'd2, 2'd0, 0, 2'd2); step("R2 and");
    ctl(3'd6, 2'd0, 2'd3, 2'd0, 0, 2'd2); step("R2 or");
    ctl(3'd7, 2'd1, 2'd2, 2'd0, 0, 2'd1); step("R2 xor");
    idle(); ld0_en = 1; ld0_val = 8'hFF; step("R7 reload D0");
    idle(); ctl(3'd0, 2'd2, 2'd0, 2'd0, 0, 2'd1); step("R9 ones flag");
    ctl(3'd1, 2'd0, 2'd0, 2'd0, 0, 2'd1); step("R9 zero flag after inc wrap");
    ctl(3'd2, 2'd0, 2'd0, 2'd0, 0, 2'd2); step("R2 dec wrap to A1");
    idle(); ld1_en = 1; ld1_val = 8'h81; ld0_en = 1; ld0_val = 8'h5A; step("R7 load shift data");
    idle(); shift_in = 1; ctl(3'd0, 2'd3, 2'd0, 2'd1, 0, 2'd1); step("R4 shift left");
    shift_in = 0; ctl(3'd0, 2'd3, 2'd0, 2'd2, 0, 2'd2); step("R4 shift right");
    shift_in = 1; ctl(3'd0, 2'd0, 2'd0, 2'd1, 0, 2'd1); step("R4 shift left from A0");
    ctl(3'd0, 2'd2, 2'd0, 2'd3, 0, 2'd2); step("R4 nibble swap");
    idle(); step("R4 shift_out holds when idle");
    or_mask = 8'h30; ctl(3'd5, 2'd2, 2'd3, 2'd0, 1, 2'd1); step("R5 or mask after and");
    or_mask = 8'h0C; shift_in = 0; ctl(3'd0, 2'd3, 2'd0, 2'd1, 1, 2'd2); step("R5 mask after shift");
    ctl(3'd1, 2'd0, 2'd0, 2'd0, 0, 2'd0); step("R6 dest 0 no write");
    ctl(3'd1, 2'd0, 2'd0, 2'd0, 0, 2'd3); step("R6 dest 3 no write");
    op_valid = 0; op_dest = 2'd1; step("R6 valid low no write");
    idle(); ld0_en = 1; ld0_val = 8'h17; ld1_en = 1; ld1_val = 8'h27; step("R7 load compare data");
    idle(); ctl(3'd0, 2'd3, 2'd0, 2'd0, 0, 2'd1); step("R8 A0 gets 0x27");
    idle(); step("R8 masked low nibble equal");
    cmp_mask = {8'h00, 8'hF0}; step("R10 independent masks");
    step("R10 empty mask equal");
    cmp_asel = {2'd2, 2'd3}; cmp_bsel = {2'd3, 2'd2}; cmp_mask = {8'hFF, 8'hFF};
    step("R10 swapped selects");
    step("R8 less-than both ways");
    ctl(3'd1, 2'd2, 2'd0, 2'd0, 0, 2'd1); ld0_en = 1; ld0_val = 8'hC3;
    step("R7 R6 load during write");
    idle(); step("R7 R6 settle");
    rst = 1; step("R1 mid-run reset");
    rst = 0; idle(); step("R1 after reset");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule